// File: doc/BRIEF.md
# Upward-Growing Stack Pointer with Limit and Floor Trap

This block keeps the stack pointer and a programmable upper limit for a 16-bit, byte-addressed, word-aligned data memory. It turns push and pop strobes into memory accesses. A push writes at the current pointer and then moves the pointer up by two. A pop first moves the pointer down by two and then reads at the new pointer. The pointer always holds the address of the next free word.

Each access is checked before it reaches memory. An access above the limit raises a stack error. An access below a fixed floor, which protects the special register region at the bottom of the address space, also raises a stack error. When a check fails, the access is blocked and a one-cycle trap pulse follows.

A frame request stores a 23-bit program counter as two words over two cycles. The low 16 PC bits go first. The second word carries the upper PC bits. For a plain call its top byte is cleared. For exception entry its top byte holds a status byte. The memory itself sits outside the block and samples `mem_we_o`, `mem_addr_o` and `mem_wdata_o` on the clock edge.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0800, `trap_o` and `busy_o` are low, and neither `mem_we_o` nor `mem_re_o` is asserted.
- R2: An accepted push drives a write of `push_data_i` at the current pointer and adds 2 to the pointer. An accepted pop subtracts 2 from the pointer and drives a read at the new value in the same cycle.
- R3: A limit write stores `lim_data_i` with bit 0 cleared, and `lim_o` shows it from the next cycle.
- R4: A push (or frame word) issued while the pointer equals the limit is accepted. One issued while the pointer is above the limit is blocked, with no memory write and no pointer change.
- R5: Any stack access whose address is below 0x0800 (a push at a low pointer, or a pop whose pre-decremented address falls below it) is blocked, with no memory access and no pointer change.
- R6: A blocked access raises `trap_o` for exactly one cycle, in the cycle after the request. The pointer is not changed by the blocked request.
- R7: A frame request with `frame_exc_i` low writes PC[15:0] at the pointer. In the next cycle, with `busy_o` high, it writes {8'h00, 1'b0, PC[22:16]} at pointer+2, so the pointer ends 4 higher. Push, pop, frame and pointer-write requests made while `busy_o` is high are ignored.
- R8: With `frame_exc_i` high, the second frame word is {status[7:0], 1'b0, PC[22:16]}.
- R9: A pointer write stores `sp_data_i` with bit 0 cleared. It takes priority over any push, pop or frame request in the same cycle, and those requests are dropped.
- R10: The second frame word is checked against the limit and floor on its own. If it fails, it is not written, a trap pulse follows, and the pointer keeps the +2 from the first word.
- R11: When several of frame, push and pop are requested together, only one is served, with the priority order frame, then push, then pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push request strobe |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Pop request strobe |
| frame_i | input | 1 | Two-word frame push request |
| frame_exc_i | input | 1 | Frame is an exception entry (status byte in the top of word two) |
| frame_pc_i | input | 23 | Program counter to store |
| frame_stat_i | input | 8 | Status byte for exception frames |
| sp_we_i | input | 1 | Direct pointer write |
| sp_data_i | input | 16 | New pointer value (bit 0 ignored) |
| lim_we_i | input | 1 | Limit register write |
| lim_data_i | input | 16 | New limit value (bit 0 ignored) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory byte address (word aligned) |
| mem_wdata_o | output | 16 | Memory write data |
| sp_o | output | 16 | Current stack pointer |
| lim_o | output | 16 | Current limit register |
| busy_o | output | 1 | Second frame word cycle in progress |
| trap_o | output | 1 | Stack error pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit data word, a 23-bit program counter, an 8-bit status byte, and both the floor and the reset pointer at 0x0800. With the reset pointer sitting exactly on the floor, the first pop after reset already tests the underflow trap. A small limit placed a few words above the floor brings the equal-to-limit acceptance, the first overflow trap and a frame whose second word crosses the limit all within a handful of pushes. Because the 23-bit counter leaves seven upper bits, the single pad bit of the second frame word is exercised with PC values whose upper bits are all ones.

// File: rtl/stkp_pkg.sv
// Shared types for the stack pointer unit.
// Assumes a single clock domain; enums are sized for synthesis.
package stkp_pkg;
    // Frame sequencing: idle, or the cycle that writes the second frame word
    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_HIGH = 1'b1
    } fr_state_e;

    // Stack operation selected for the current cycle
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_FRLO = 3'd3,
        OP_FRHI = 3'd4
    } stk_op_e;
endpackage

// File: rtl/stkp_frame_build.sv
// Builds the two words of a call or exception frame from a program counter.
// Word one is PC[DW-1:0]. Word two is {top byte, zero pad, upper PC bits}.
// For an exception frame the top byte is the status byte, otherwise it is zero.
// Assumes PCW > DW and DW - SW - (PCW - DW) >= 1.
module stkp_frame_build #(
    parameter int DW  = 16,
    parameter int PCW = 23,
    parameter int SW  = 8
) (
    input  logic [PCW-1:0] pc_i,
    input  logic [SW-1:0]  stat_i,
    input  logic           exc_i,
    output logic [DW-1:0]  lo_o,
    output logic [DW-1:0]  hi_o
);
    localparam int PCH = PCW - DW;
    localparam int PAD = DW - SW - PCH;

    logic [SW-1:0] top_byte;

    // Choose the top byte: status on exception entry, zero for a call
    always_comb begin
        top_byte = exc_i ? stat_i : '0;
    end

    assign lo_o = pc_i[DW-1:0];
    assign hi_o = {top_byte, {PAD{1'b0}}, pc_i[PCW-1:DW]};
endmodule

// File: rtl/stkp_bound_chk.sv
// Range check for one stack effective address.
// Flags an address below the fixed floor, and, when chk_hi is set, an
// address above the limit. Equality with the limit is allowed.
// Purely combinational; the caller decides what to block.
module stkp_bound_chk #(
    parameter int            DW    = 16,
    parameter logic [DW-1:0] FLOOR = 16'h0800
) (
    input  logic [DW-1:0] ea_i,
    input  logic [DW-1:0] lim_i,
    input  logic          chk_hi_i,
    output logic          bad_o
);
    logic below_floor;
    logic above_lim;

    // Compare the address against both bounds
    always_comb begin
        below_floor = (ea_i < FLOOR);
        above_lim   = chk_hi_i && (ea_i > lim_i);
        bad_o       = below_floor || above_lim;
    end
endmodule

// File: rtl/stack_ptr_unit.sv
// Stack pointer unit: pointer, limit, push/pop address generation,
// limit and floor trap, and two-cycle frame push.
// Assumes an external synchronous memory that writes on the clock edge
// when mem_we_o is high. The limit register is not reset; software must
// load it before the first push. One stack access per cycle.
module stack_ptr_unit #(
    parameter int            DW       = 16,
    parameter int            PCW      = 23,
    parameter int            SW       = 8,
    parameter logic [DW-1:0] FLOOR    = 16'h0800,
    parameter logic [DW-1:0] SP_RESET = 16'h0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_i,
    input  logic [DW-1:0]  push_data_i,
    input  logic           pop_i,
    input  logic           frame_i,
    input  logic           frame_exc_i,
    input  logic [PCW-1:0] frame_pc_i,
    input  logic [SW-1:0]  frame_stat_i,
    input  logic           sp_we_i,
    input  logic [DW-1:0]  sp_data_i,
    input  logic           lim_we_i,
    input  logic [DW-1:0]  lim_data_i,
    output logic           mem_we_o,
    output logic           mem_re_o,
    output logic [DW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    output logic [DW-1:0]  sp_o,
    output logic [DW-1:0]  lim_o,
    output logic           busy_o,
    output logic           trap_o
);
    import stkp_pkg::*;

    localparam logic [DW-1:0] WSTEP = DW'(2);
    localparam logic [DW-1:0] ALIGN = ~DW'(1);

    fr_state_e      state_q;
    stk_op_e        op;
    logic [DW-1:0]  sp_q;
    logic [DW-1:0]  lim_q;
    logic [DW-1:0]  hi_q;
    logic           trap_q;
    logic [DW-1:0]  ea;
    logic           chk_hi;
    logic           bad;
    logic [DW-1:0]  fr_lo;
    logic [DW-1:0]  fr_hi;

    stkp_frame_build #(.DW(DW), .PCW(PCW), .SW(SW)) u_frame (
        .pc_i   (frame_pc_i),
        .stat_i (frame_stat_i),
        .exc_i  (frame_exc_i),
        .lo_o   (fr_lo),
        .hi_o   (fr_hi)
    );

    stkp_bound_chk #(.DW(DW), .FLOOR(FLOOR)) u_bound (
        .ea_i     (ea),
        .lim_i    (lim_q),
        .chk_hi_i (chk_hi),
        .bad_o    (bad)
    );

    // Select this cycle's operation: frame word two, then pointer write, then frame, push, pop
    always_comb begin
        op = OP_NONE;
        if (state_q == FR_HIGH) begin
            op = OP_FRHI;
        end else if (!sp_we_i) begin
            if (frame_i)     op = OP_FRLO;
            else if (push_i) op = OP_PUSH;
            else if (pop_i)  op = OP_POP;
        end
    end

    // Form the effective address: pre-decrement for pop, current pointer otherwise
    always_comb begin
        ea     = (op == OP_POP) ? (sp_q - WSTEP) : sp_q;
        chk_hi = (op != OP_POP);
    end

    // Drive the memory strobes only when the access passes both bounds
    always_comb begin
        mem_we_o    = (op == OP_PUSH || op == OP_FRLO || op == OP_FRHI) && !bad;
        mem_re_o    = (op == OP_POP) && !bad;
        mem_addr_o  = ea;
        unique case (op)
            OP_PUSH: mem_wdata_o = push_data_i;
            OP_FRLO: mem_wdata_o = fr_lo;
            OP_FRHI: mem_wdata_o = hi_q;
            default: mem_wdata_o = '0;
        endcase
    end

    // Pointer update: direct write, post-increment on write, pre-decrement on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_RESET;
        end else if (state_q == FR_IDLE && sp_we_i) begin
            sp_q <= sp_data_i & ALIGN;
        end else if (mem_we_o) begin
            sp_q <= sp_q + WSTEP;
        end else if (mem_re_o) begin
            sp_q <= ea;
        end
    end

    // Limit register: loaded on write with bit 0 cleared, deliberately left unreset
    always_ff @(posedge clk) begin
        if (lim_we_i) begin
            lim_q <= lim_data_i & ALIGN;
        end
    end

    // Frame sequencer: enter the second-word cycle after an accepted first word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            hi_q    <= '0;
        end else if (op == OP_FRLO && !bad) begin
            state_q <= FR_HIGH;
            hi_q    <= fr_hi;
        end else begin
            state_q <= FR_IDLE;
        end
    end

    // Trap pulse: one cycle for each blocked request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= 1'b0;
        end else begin
            trap_q <= (op != OP_NONE) && bad;
        end
    end

    assign sp_o   = sp_q;
    assign lim_o  = lim_q;
    assign busy_o = (state_q == FR_HIGH);
    assign trap_o = trap_q;
endmodule

// File: rtl/stkp_chk.sv
// Property checker for stack_ptr_unit, attached by bind.
// Observes ports only; assumes the same clock and reset as the unit.
module stkp_chk #(
    parameter int            DW    = 16,
    parameter logic [DW-1:0] FLOOR = 16'h0800
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we_o,
    input logic          mem_re_o,
    input logic [DW-1:0] mem_addr_o,
    input logic [DW-1:0] sp_o,
    input logic [DW-1:0] lim_o,
    input logic          busy_o,
    input logic          trap_o,
    input logic          lim_we_i,
    input logic          sp_we_i,
    input logic [DW-1:0] sp_data_i
);
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> sp_o == $past(mem_addr_o) + DW'(2)); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> sp_o == $past(mem_addr_o)); // R2
    AST_LIM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we_i |=> !lim_o[0]); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_addr_o <= lim_o); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> mem_addr_o >= FLOOR); // R5
    AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $stable(sp_o)); // R6
    AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !mem_re_o); // R7
    AST_SP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we_i && !busy_o) |=> sp_o == ($past(sp_data_i) & ~DW'(1))); // R9
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o)); // R11
endmodule

bind stack_ptr_unit stkp_chk #(.DW(DW), .FLOOR(FLOOR)) u_stkp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .sp_o       (sp_o),
    .lim_o      (lim_o),
    .busy_o     (busy_o),
    .trap_o     (trap_o),
    .lim_we_i   (lim_we_i),
    .sp_we_i    (sp_we_i),
    .sp_data_i  (sp_data_i)
);

// File: tb/stack_ptr_unit_test.sv
// Scoreboard bench: the driver predicts memory events into a queue and
// the monitor compares them at each falling edge.
module stack_ptr_unit_test;
    localparam logic [15:0] FLOOR = 16'h0800;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_i, pop_i, frame_i, frame_exc_i, sp_we_i, lim_we_i;
    logic [15:0] push_data_i, sp_data_i, lim_data_i;
    logic [22:0] frame_pc_i;
    logic [7:0]  frame_stat_i;
    logic        mem_we_o, mem_re_o, busy_o, trap_o;
    logic [15:0] mem_addr_o, mem_wdata_o, sp_o, lim_o;

    logic [15:0] mem [0:1023];
    int          vectors = 0;
    int          fails   = 0;
    bit          mon_en  = 1'b0;

    int          q_kind [$];
    logic [15:0] q_addr [$];
    logic [15:0] q_data [$];
    string       q_tag  [$];

    logic [15:0] m_sp, m_lim, m_hi;
    bit          m_busy;
    logic [15:0] m_mem [int];

    always #10 clk = ~clk;

    stack_ptr_unit uut (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
        .frame_i(frame_i), .frame_exc_i(frame_exc_i),
        .frame_pc_i(frame_pc_i), .frame_stat_i(frame_stat_i),
        .sp_we_i(sp_we_i), .sp_data_i(sp_data_i),
        .lim_we_i(lim_we_i), .lim_data_i(lim_data_i),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .sp_o(sp_o), .lim_o(lim_o), .busy_o(busy_o), .trap_o(trap_o)
    );

    always @(posedge clk) if (mem_we_o) mem[mem_addr_o[10:1]] <= mem_wdata_o;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic enq(input int k, input logic [15:0] a, input logic [15:0] d, input string tag);
        q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
    endtask

    // Monitor: kind 0 = write, 1 = read, 2 = trap
    task automatic observe(input int k, input logic [15:0] a, input logic [15:0] d);
        int ek; logic [15:0] ea, ed; string t;
        vectors++;
        if (q_kind.size() == 0) begin
            fails++;
            $display("FAIL unexpected event actual=kind%0d@%h expected=none", k, a);
            return;
        end
        ek = q_kind.pop_front(); ea = q_addr.pop_front();
        ed = q_data.pop_front(); t  = q_tag.pop_front();
        if (ek != k || (k != 2 && (ea !== a || ed !== d))) begin
            fails++;
            $display("FAIL %s actual=kind%0d@%h:%h expected=kind%0d@%h:%h", t, k, a, d, ek, ea, ed);
        end
    endtask

    always @(negedge clk) if (mon_en) begin
        if (trap_o)   observe(2, 16'h0, 16'h0);
        if (mem_we_o) observe(0, mem_addr_o, mem_wdata_o);
        if (mem_re_o) observe(1, mem_addr_o, mem[mem_addr_o[10:1]]);
    end

    function automatic bit out_of_range(input logic [15:0] a, input bit hi);
        return (a < FLOOR) || (hi && a > m_lim);
    endfunction

    // Driver: apply one cycle of inputs and predict its effect
    task automatic step(input string tag, input logic p, input logic q, input logic f,
                        input logic x, input logic [15:0] d, input logic [22:0] pc,
                        input logic [7:0] st, input logic sw, input logic [15:0] sd,
                        input logic lw, input logic [15:0] ld);
        logic [15:0] ea;
        push_i = p; pop_i = q; frame_i = f; frame_exc_i = x; push_data_i = d;
        frame_pc_i = pc; frame_stat_i = st; sp_we_i = sw; sp_data_i = sd;
        lim_we_i = lw; lim_data_i = ld;
        if (m_busy) begin
            if (out_of_range(m_sp, 1'b1)) enq(2, 0, 0, tag);
            else begin enq(0, m_sp, m_hi, tag); m_mem[int'(m_sp)] = m_hi; m_sp += 2; end
            m_busy = 1'b0;
        end else if (sw) begin
            m_sp = sd & 16'hFFFE;
        end else if (f) begin
            if (out_of_range(m_sp, 1'b1)) enq(2, 0, 0, tag);
            else begin
                enq(0, m_sp, pc[15:0], tag); m_mem[int'(m_sp)] = pc[15:0]; m_sp += 2;
                m_busy = 1'b1; m_hi = {x ? st : 8'h00, 1'b0, pc[22:16]};
            end
        end else if (p) begin
            if (out_of_range(m_sp, 1'b1)) enq(2, 0, 0, tag);
            else begin enq(0, m_sp, d, tag); m_mem[int'(m_sp)] = d; m_sp += 2; end
        end else if (q) begin
            ea = m_sp - 16'd2;
            if (out_of_range(ea, 1'b0)) enq(2, 0, 0, tag);
            else begin enq(1, ea, m_mem[int'(ea)], tag); m_sp = ea; end
        end
        if (lw) m_lim = ld & 16'hFFFE;
        @(posedge clk); #2;
        push_i = 0; pop_i = 0; frame_i = 0; frame_exc_i = 0; sp_we_i = 0; lim_we_i = 0;
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic do_push(input string tag, input logic [15:0] d);
        step(tag, 1, 0, 0, 0, d, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic do_pop(input string tag);
        step(tag, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic set_sp(input string tag, input logic [15:0] v);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0);
    endtask
    task automatic set_lim(input string tag, input logic [15:0] v);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v);
    endtask
    task automatic do_frame(input string tag, input logic x, input logic [22:0] pc, input logic [7:0] st);
        step(tag, 0, 0, 1, x, 0, pc, st, 0, 0, 0, 0);
        check({tag, " busy"}, {15'd0, busy_o}, 16'd1);
        idle(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all) actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 0; push_i = 0; pop_i = 0; frame_i = 0; frame_exc_i = 0; sp_we_i = 0;
        lim_we_i = 0; push_data_i = 0; sp_data_i = 0; lim_data_i = 0;
        frame_pc_i = 0; frame_stat_i = 0;
        m_sp = 16'h0800; m_lim = 16'hFFFE; m_busy = 0; m_hi = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 sp", sp_o, 16'h0800);
        check("R1 trap", {15'd0, trap_o}, 16'd0);
        check("R1 busy", {15'd0, busy_o}, 16'd0);
        check("R1 access", {14'd0, mem_we_o, mem_re_o}, 16'd0);
        mon_en = 1;
        @(posedge clk); #2;
        // R3: limit bit 0 forced clear
        set_lim("R3", 16'h0811);
        check("R3 lim", lim_o, 16'h0810);
        // R2: push then pop
        do_push("R2 push", 16'h1111);
        check("R2 sp", sp_o, 16'h0802);
        do_push("R2 push", 16'h2222);
        do_pop("R2 pop");
        check("R2 sp", sp_o, 16'h0802);
        do_pop("R2 pop");
        check("R2 sp", sp_o, 16'h0800);
        // R5: pop below floor
        do_pop("R5 pop floor");
        check("R5 sp", sp_o, 16'h0800);
        // R4: fill to the limit, equal passes, next traps
        for (int i = 0; i < 8; i++) do_push("R2 fill", 16'h0100 + 16'(i));
        check("R4 sp at lim", sp_o, 16'h0810);
        do_push("R4 push at lim", 16'hAAAA);
        check("R4 sp", sp_o, 16'h0812);
        do_push("R4 push over lim", 16'hBBBB);
        check("R4 sp blocked", sp_o, 16'h0812);
        // R11: push wins over pop
        set_lim("R3", 16'h0900);
        step("R11 push+pop", 1, 1, 0, 0, 16'h3333, 0, 0, 0, 0, 0, 0);
        check("R11 sp", sp_o, 16'h0814);
        // R9: pointer write wins and clears bit 0
        step("R9 sp+push", 1, 0, 0, 0, 16'h4444, 0, 0, 1, 16'h0821, 0, 0);
        check("R9 sp", sp_o, 16'h0820);
        // R7: call frame
        do_frame("R7 call", 1'b0, 23'h5A1234, 8'hC3);
        check("R7 sp", sp_o, 16'h0824);
        // R8: exception frame
        do_frame("R8 exc", 1'b1, 23'h7FBEEF, 8'hC3);
        check("R8 sp", sp_o, 16'h0828);
        // R7: push during busy ignored
        step("R7 frame", 0, 0, 1, 0, 0, 23'h012345, 0, 0, 0, 0, 0);
        step("R7 push busy", 1, 0, 0, 0, 16'h5555, 0, 0, 0, 0, 0, 0);
        check("R7 sp", sp_o, 16'h082C);
        // R10: second frame word over the limit
        set_lim("R3", 16'h0830);
        set_sp("R9", 16'h0830);
        do_frame("R10 frame hi trap", 1'b0, 23'h000ABC, 8'h00);
        check("R10 sp", sp_o, 16'h0832);
        // R5 and R6: push below floor, single trap pulse
        set_sp("R9", 16'h0700);
        do_push("R5 push floor", 16'h6666);
        check("R6 trap high", {15'd0, trap_o}, 16'd1);
        check("R5 sp", sp_o, 16'h0700);
        idle("R6");
        check("R6 trap low", {15'd0, trap_o}, 16'd0);
        // R8: read back the exception frame word two
        set_sp("R9", 16'h0828);
        do_pop("R8 pop");
        check("R8 sp", sp_o, 16'h0826);
        idle("end"); idle("end"); idle("end");
        check("queue drained", 16'(q_kind.size()), 16'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule